// File: doc/BRIEF.md
# Scroll Step Timing Engine

This block paces continuous scrolling for a page-organised display controller. It holds one scroll setup, which is either horizontal-only or vertical-plus-horizontal and moves left or right. The setup gives a first page, a last page, a 3-bit step-rate code and a vertical row offset. The block also holds the vertical scroll area, made of a number of fixed rows at the top followed by a number of scrolling rows. A later setup replaces the earlier one, and any setup whose fields are inconsistent is dropped without effect.

Once started, the block counts incoming frame ticks. Every time a full step interval has elapsed, it raises a one-cycle shift strobe that carries the shift direction and a mask of the pages to shift. For a vertical-plus-horizontal setup, each step also advances a row offset by the programmed amount, wrapping inside the scroll area. Frame tick generation and display memory lie outside the block.

The control is a three-state machine. `ST_IDLE` is the stopped state. `ST_COUNT` counts frame ticks. `ST_STEP` is the one-cycle strobe state. The transitions are as follows. *start* goes from `ST_IDLE` to `ST_COUNT` when activation is accepted. *expire* goes from `ST_COUNT` to `ST_STEP` on the tick that completes the interval. *resume* goes from `ST_STEP` back to `ST_COUNT`, always. *stop* goes from any state to `ST_IDLE` on deactivation.

Top module: `scroll_step_engine`

## Requirements
- R1: After reset the block is in `ST_IDLE` with `scrolling`=0, `shift_strobe`=0, `page_mask`=0 and `row_offset`=0. The stored setup is horizontal-only, moving right, covering pages 0 to 7, with rate code 0. The stored area has 0 fixed rows and 64 scroll rows.
- R2: The step interval is selected by the rate code. Codes 0,1,2,3,4,5,6,7 give 5,64,128,256,3,4,25,2 frames per step respectively.
- R3: After an accepted activation, the first strobe comes after one full interval, and every later strobe comes one interval after the previous one. `shift_strobe` is high for exactly the one cycle that follows the clock edge at which the completing `frame_tick` was sampled.
- R4: A setup command (`cfg_valid`) replaces the stored setup only under three conditions: `cfg_last` >= `cfg_first`, the offset is non-zero when `cfg_vert`=1, and the block is not scrolling. In every other case it is ignored. The last accepted setup is the one used.
- R5: `act_on` is accepted only from `ST_IDLE`, and only when the stored setup is horizontal-only or its vertical offset is less than the stored scroll-row count. Otherwise it is ignored.
- R6: `act_off` stops scrolling at the next edge from any state, and it wins over a simultaneous `act_on`. While stopped, no strobe occurs and `row_offset` is 0.
- R7: While scrolling, `page_mask` bit i is 1 exactly when the stored first page <= i <= the stored last page. `shift_left` (1=left, 0=right) follows the stored direction. `page_mask` is 0 when idle.
- R8: On each step of a vertical setup, `row_offset` becomes (`row_offset` + offset) mod scroll-row count, so it wraps from the last row of the area back to its first. A horizontal-only setup leaves it at 0.
- R9: An area command (`area_valid`) is ignored if the scroll-row count is 0, if the scroll-row count exceeds `mux_rows`, if fixed rows plus scroll rows exceed `mux_rows`, or if the block is scrolling.
- R10: A `frame_tick` that arrives during the `ST_STEP` cycle counts toward the next interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Scroll setup command strobe |
| cfg_vert | input | 1 | 1 = vertical-plus-horizontal, 0 = horizontal-only |
| cfg_left | input | 1 | 1 = shift left, 0 = shift right |
| cfg_first | input | 3 | First page to shift |
| cfg_last | input | 3 | Last page to shift |
| cfg_rate | input | 3 | Step-rate code |
| cfg_voff | input | 6 | Vertical rows advanced per step |
| area_valid | input | 1 | Scroll area command strobe |
| area_fixed | input | 6 | Fixed rows at top |
| area_rows | input | 7 | Scrolling rows below the fixed rows |
| mux_rows | input | 7 | Active row count of the panel |
| act_on | input | 1 | Start scrolling |
| act_off | input | 1 | Stop scrolling |
| frame_tick | input | 1 | One pulse per display frame |
| scrolling | output | 1 | Block is running |
| shift_strobe | output | 1 | One-cycle step pulse |
| shift_left | output | 1 | Direction of the current shift |
| page_mask | output | 8 | Pages affected by the shift |
| row_offset | output | 6 | Current vertical offset within the scroll area |

## Verification
Several properties are checked on every cycle by the assertions. The tick counter is never zero while counting. A stop always lands in the idle state. The stored page range is never reversed. The page mask population always matches that range. The row offset stays inside the scroll area and changes only on a step. Other behaviours are visible only through the bench's scenarios. These are the exact frame count for each of the eight rate codes, the rule that the last valid setup wins, the rejection of activations and commands, the wrap sequence of the vertical offset, and the counting of a tick that falls in the step cycle.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
    localparam int PAGE_W = 3;
    localparam int NPAGES = 1 << PAGE_W;
    localparam int ROW_W  = 6;
    localparam int RATE_W = 3;
    localparam int CNT_W  = 9;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_STEP  = 2'd2
    } scroll_state_t;

    typedef struct packed {
        logic              vert;
        logic              left;
        logic [PAGE_W-1:0] first;
        logic [PAGE_W-1:0] last;
        logic [RATE_W-1:0] rate;
        logic [ROW_W-1:0]  voff;
    } scroll_setup_t;

    function automatic logic [CNT_W-1:0] rate_frames(input logic [RATE_W-1:0] code);
        logic [CNT_W-1:0] f;
        unique case (code)
            3'd0: f = CNT_W'(5);
            3'd1: f = CNT_W'(64);
            3'd2: f = CNT_W'(128);
            3'd3: f = CNT_W'(256);
            3'd4: f = CNT_W'(3);
            3'd5: f = CNT_W'(4);
            3'd6: f = CNT_W'(25);
            default: f = CNT_W'(2);
        endcase
        return f;
    endfunction
endpackage

// File: rtl/scroll_setup_regs.sv
module scroll_setup_regs
    import scroll_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold,
    input  logic                cfg_valid,
    input  scroll_setup_t       cfg_in,
    input  logic                area_valid,
    input  logic [ROW_W-1:0]    area_fixed,
    input  logic [ROW_W:0]      area_rows,
    input  logic [ROW_W:0]      mux_rows,
    output scroll_setup_t       setup_q,
    output logic [ROW_W-1:0]    fixed_q,
    output logic [ROW_W:0]      rows_q
);
    localparam logic [ROW_W:0] ROWS_RESET = (ROW_W+1)'(1 << ROW_W);

    logic              cfg_ok;
    logic              area_ok;
    logic [ROW_W+1:0]  area_sum;

    always_comb begin
        cfg_ok   = cfg_valid && !hold && (cfg_in.last >= cfg_in.first) &&
                   (!cfg_in.vert || (cfg_in.voff != '0));
        area_sum = {2'b00, area_fixed} + {1'b0, area_rows};
        area_ok  = area_valid && !hold && (area_rows != '0) &&
                   (area_rows <= mux_rows) && (area_sum <= {1'b0, mux_rows});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_q <= '{vert: 1'b0, left: 1'b0, first: '0, last: '1, rate: '0, voff: '0};
            fixed_q <= '0;
            rows_q  <= ROWS_RESET;
        end else begin
            if (cfg_ok) setup_q <= cfg_in;
            if (area_ok) begin
                fixed_q <= area_fixed;
                rows_q  <= area_rows;
            end
        end
    end

    // R4
    page_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_q.last >= setup_q.first);
endmodule

// File: rtl/scroll_step_fsm.sv
module scroll_step_fsm
    import scroll_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              frame_tick,
    input  logic [RATE_W-1:0] rate,
    output logic              running,
    output logic              step
);
    scroll_state_t    state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] frames;

    always_comb begin
        frames  = rate_frames(rate);
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) begin
                    state_d = ST_COUNT;
                    cnt_d   = frames;
                end
            end
            ST_COUNT: begin
                if (frame_tick) begin
                    if (cnt_q == CNT_W'(1)) state_d = ST_STEP;
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_STEP: begin
                state_d = ST_COUNT;
                cnt_d   = frame_tick ? frames - CNT_W'(1) : frames;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
        if (stop_req) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        running = (state_q != ST_IDLE);
        step    = (state_q == ST_STEP);
    end

    // R3
    count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (cnt_q != '0));
    // R6
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (state_q == ST_IDLE));
endmodule

// File: rtl/scroll_row_advance.sv
module scroll_row_advance
    import scroll_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             vert,
    input  logic [ROW_W-1:0] voff,
    input  logic [ROW_W:0]   rows,
    output logic [ROW_W-1:0] row_q
);
    logic [ROW_W:0] sum;
    logic [ROW_W:0] wrapped;

    always_comb begin
        sum     = {1'b0, row_q} + {1'b0, voff};
        wrapped = (sum >= rows) ? sum - rows : sum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) row_q <= '0;
        else if (step && vert) row_q <= wrapped[ROW_W-1:0];
    end

    // R8
    row_in_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_q != '0) |-> ({1'b0, row_q} < rows));
    // R8
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(row_q));
endmodule

// File: rtl/scroll_step_engine.sv
module scroll_step_engine
    import scroll_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_vert,
    input  logic              cfg_left,
    input  logic [2:0]        cfg_first,
    input  logic [2:0]        cfg_last,
    input  logic [2:0]        cfg_rate,
    input  logic [5:0]        cfg_voff,
    input  logic              area_valid,
    input  logic [5:0]        area_fixed,
    input  logic [6:0]        area_rows,
    input  logic [6:0]        mux_rows,
    input  logic              act_on,
    input  logic              act_off,
    input  logic              frame_tick,
    output logic              scrolling,
    output logic              shift_strobe,
    output logic              shift_left,
    output logic [7:0]        page_mask,
    output logic [5:0]        row_offset
);
    scroll_setup_t    cfg_in, setup_q;
    logic [ROW_W-1:0] fixed_q;
    logic [ROW_W:0]   rows_q;
    logic             running, step, start_req;

    assign cfg_in = '{vert: cfg_vert, left: cfg_left, first: cfg_first,
                      last: cfg_last, rate: cfg_rate, voff: cfg_voff};

    scroll_setup_regs u_regs (
        .clk(clk), .rst_n(rst_n), .hold(running),
        .cfg_valid(cfg_valid), .cfg_in(cfg_in),
        .area_valid(area_valid), .area_fixed(area_fixed), .area_rows(area_rows),
        .mux_rows(mux_rows), .setup_q(setup_q), .fixed_q(fixed_q), .rows_q(rows_q)
    );

    assign start_req = act_on && !act_off &&
                       (!setup_q.vert || ({1'b0, setup_q.voff} < rows_q));

    scroll_step_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(act_off),
        .frame_tick(frame_tick), .rate(setup_q.rate),
        .running(running), .step(step)
    );

    scroll_row_advance u_row (
        .clk(clk), .rst_n(rst_n), .clear(act_off || !running), .step(step),
        .vert(setup_q.vert), .voff(setup_q.voff), .rows(rows_q), .row_q(row_offset)
    );

    for (genvar i = 0; i < NPAGES; i++) begin : g_mask
        assign page_mask[i] = running && (PAGE_W'(i) >= setup_q.first) &&
                              (PAGE_W'(i) <= setup_q.last);
    end

    assign scrolling    = running;
    assign shift_strobe = step;
    assign shift_left   = setup_q.left;

    // R7
    mask_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> ($countones(page_mask) == (int'(setup_q.last) - int'(setup_q.first) + 1)));
    // R7
    mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (page_mask == '0));
    // R5
    start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(running) && setup_q.vert) |-> ({1'b0, setup_q.voff} < rows_q));
    // R3
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_strobe |=> !shift_strobe);
endmodule

// File: tb/scroll_step_engine_test.sv
module scroll_step_engine_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_valid = 0, cfg_vert = 0, cfg_left = 0;
    logic [2:0] cfg_first = 0, cfg_last = 0, cfg_rate = 0;
    logic [5:0] cfg_voff = 0;
    logic area_valid = 0;
    logic [5:0] area_fixed = 0;
    logic [6:0] area_rows = 0;
    logic [6:0] mux_rows = 7'd64;
    logic act_on = 0, act_off = 0, frame_tick = 0;
    logic scrolling, shift_strobe, shift_left;
    logic [7:0] page_mask;
    logic [5:0] row_offset;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scroll_step_engine uut (.*);

    task automatic cyc();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setup(input bit v, input bit l, input int f, input int la, input int r, input int vo);
        cfg_vert = v; cfg_left = l; cfg_first = 3'(f); cfg_last = 3'(la);
        cfg_rate = 3'(r); cfg_voff = 6'(vo); cfg_valid = 1; cyc(); cfg_valid = 0;
    endtask

    task automatic area(input int fx, input int rw);
        area_fixed = 6'(fx); area_rows = 7'(rw); area_valid = 1; cyc(); area_valid = 0;
    endtask

    task automatic start();  act_on = 1;  cyc(); act_on = 0;  endtask
    task automatic stop();   act_off = 1; cyc(); act_off = 0; endtask
    task automatic tick();   frame_tick = 1; cyc(); frame_tick = 0; endtask

    task automatic ticks_to_step(output int n);
        n = 0;
        for (int i = 1; i <= 300; i++) begin
            tick();
            if (shift_strobe) begin n = i; break; end
        end
    endtask

    task automatic t_reset();
        chk(scrolling == 0 && shift_strobe == 0, "R1 idle", scrolling, 0);
        chk(page_mask == 0 && row_offset == 0, "R1 mask/row", page_mask, 0);
        start();
        chk(page_mask == 8'hFF && shift_left == 0, "R1 default pages", page_mask, 255);
        begin int n; ticks_to_step(n); chk(n == 5, "R1 default rate", n, 5); end
        cyc(); stop();
    endtask

    task automatic t_rates();
        int exp[8] = '{5, 64, 128, 256, 3, 4, 25, 2};
        for (int c = 0; c < 8; c++) begin
            int n;
            setup(0, 0, 0, 7, c, 0); start();
            ticks_to_step(n);
            chk(n == exp[c], "R2 rate code", n, exp[c]);
            cyc();
            chk(shift_strobe == 0, "R3 strobe one cycle", shift_strobe, 0);
            ticks_to_step(n);
            chk(n == exp[c], "R3 repeat interval", n, exp[c]);
            cyc(); stop();
        end
    endtask

    task automatic t_last_wins();
        setup(0, 1, 1, 3, 7, 0);
        setup(0, 0, 2, 5, 7, 0);
        setup(0, 0, 6, 4, 7, 0);   // reversed: ignored
        start();
        chk(page_mask == 8'b0011_1100, "R4 last valid setup", page_mask, 8'h3C);
        chk(page_mask != 8'h00 && shift_left == 0, "R7 dir right", shift_left, 0);
        setup(0, 1, 0, 0, 7, 0);   // while running: ignored
        chk(page_mask == 8'h3C && shift_left == 0, "R4 setup while running", page_mask, 8'h3C);
        act_on = 1; cyc(); act_on = 0;
        chk(scrolling == 1, "R5 act_on while running", scrolling, 1);
        stop();
        setup(1, 1, 4, 4, 7, 0);   // vertical offset zero: ignored
        start();
        chk(page_mask == 8'h3C && shift_left == 0, "R4 zero offset rejected", page_mask, 8'h3C);
        stop();
    endtask

    task automatic t_vertical();
        int n;
        int exp[4] = '{7, 14, 1, 8};
        area(0, 20);
        setup(1, 1, 1, 2, 7, 7);
        start();
        chk(page_mask == 8'b0000_0110 && shift_left == 1, "R7 mask/left", page_mask, 6);
        for (int s = 0; s < 4; s++) begin
            ticks_to_step(n); cyc();
            chk(row_offset == exp[s], "R8 row wrap", row_offset, exp[s]);
        end
        stop();
        chk(scrolling == 0 && row_offset == 0, "R6 stop clears", row_offset, 0);
        for (int i = 0; i < 4; i++) tick();
        chk(shift_strobe == 0 && page_mask == 0, "R6 no strobe idle", shift_strobe, 0);
    endtask

    task automatic t_rejects();
        area(0, 10);
        setup(1, 0, 0, 7, 7, 12);
        start();
        chk(scrolling == 0, "R5 offset >= rows", scrolling, 0);
        mux_rows = 7'd32;
        area(0, 40);
        area(10, 25);
        setup(1, 0, 0, 7, 7, 25);
        start();
        chk(scrolling == 0, "R9 area over mux ignored", scrolling, 0);
        area(0, 0);
        setup(1, 0, 0, 7, 7, 5);
        start();
        chk(scrolling == 1, "R9 zero rows ignored", scrolling, 1);
        area(0, 3);
        stop();
        setup(1, 0, 0, 7, 7, 5);
        start();
        chk(scrolling == 1, "R9 area while running ignored", scrolling, 1);
        stop();
        mux_rows = 7'd64;
        act_on = 1; act_off = 1; cyc(); act_on = 0; act_off = 0;
        chk(scrolling == 0, "R6 off wins", scrolling, 0);
    endtask

    task automatic t_tick_in_step();
        int exp[6] = '{0, 1, 0, 1, 0, 1};
        setup(0, 0, 0, 7, 7, 0); start();
        frame_tick = 1;
        for (int i = 0; i < 6; i++) begin
            cyc();
            chk(shift_strobe == exp[i], "R10 tick in step counted", shift_strobe, exp[i]);
        end
        frame_tick = 0;
        stop();
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1; cyc();
        t_reset();
        t_rates();
        t_last_wins();
        t_vertical();
        t_rejects();
        t_tick_in_step();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule